// File: doc/BRIEF.md
# Interrupt Controller Initialization Word Sequencer

This block is the register-write front end of an eight-level interrupt controller. Software writes bytes through one address bit (`wr_a0`) and an 8-bit data bus. A byte written with the address bit low and data bit 4 set always opens a new initialization sequence. The sequencer then collects the words that must follow: two, three or four bytes in all, depending on flags in the opening word. Once the last expected word arrives, the block accepts operation commands. Only mask loads and status-read selection are decoded here.

At the start of every sequence the block applies fixed defaults. It clears the mask, sets status reads back to the request register and zeroes the fourth-word options. It also raises a one-cycle strobe. The priority core uses that strobe to reset its edge detectors, to give the lowest priority to level 7, to set the slave address to 7 and to clear special mask mode. The captured configuration goes out on plain ports for the priority core and the vector sequencer. A combinational read path returns the mask or the selected status register.

Top module: `icw_sequencer`

## Requirements
- R1: A write with `wr_a0`=0 and `wr_data[4]`=1 starts a new sequence from any state. In the next cycle `init_done` is 0 and `init_clr` is 1. `init_clr` is high only in the cycle that follows such a write.
- R2: The opening word loads the configuration: bit 0 sets `cfg_need4`, bit 1 sets `cfg_single`, bit 2 sets `cfg_intv4`, bit 3 sets `cfg_level`, and bits 7..5 go to `vec_page[2:0]`.
- R3: The opening word clears `irq_mask` to 0 and clears `stat_isr`, so that status reads select the request register.
- R4: The first `wr_a0`=1 write after the opening word is stored in `vec_page[10:3]`.
- R5: A third word is expected only when `cfg_single`=0, and it is stored in `casc_cfg`. A fourth word is expected only when `cfg_need4`=1.
- R6: In the fourth word, bit 0 sets `cfg_mode86`, bit 1 sets `cfg_aeoi` and bit 3 sets `cfg_buffered`. The opening word zeroes all three, so they stay 0 when no fourth word is expected.
- R7: `init_done` rises in the cycle after the last expected word. While a sequence is open, writes with `wr_a0`=0 and `wr_data[4]`=0 change nothing.
- R8: While `init_done`=1, a write with `wr_a0`=1 loads `irq_mask` from `wr_data` in the next cycle.
- R9: While `init_done`=1, a write with `wr_a0`=0, `wr_data[4]`=0, `wr_data[3]`=1 and `wr_data[1]`=1 sets `stat_isr` to `wr_data[0]`. Other writes with `wr_a0`=0 and `wr_data[4]`=0 leave it unchanged.
- R10: `rd_data` equals `irq_mask` when `rd_a0`=1. When `rd_a0`=0 it equals `isr_in` if `stat_isr`=1 and `irr_in` otherwise, within the same cycle.
- R11: After reset, `init_done` is 0 and every configuration output and `irq_mask` are 0. Writes with `wr_a0`=1 made before any opening word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_a0 | input | 1 | Write address bit |
| wr_data | input | 8 | Write data |
| rd_a0 | input | 1 | Read address bit |
| irr_in | input | 8 | Request register from the priority core |
| isr_in | input | 8 | In-service register from the priority core |
| rd_data | output | 8 | Read data |
| init_clr | output | 1 | One-cycle default strobe after an opening word |
| init_done | output | 1 | Initialization complete |
| cfg_level | output | 1 | Level-triggered inputs |
| cfg_intv4 | output | 1 | Call interval of 4 |
| cfg_single | output | 1 | Single controller, no cascade |
| cfg_need4 | output | 1 | Fourth word expected |
| cfg_mode86 | output | 1 | 16-bit processor vector mode |
| cfg_aeoi | output | 1 | Automatic end of interrupt |
| cfg_buffered | output | 1 | Buffered mode |
| vec_page | output | 11 | Vector address bits 15..5 |
| casc_cfg | output | 8 | Cascade word |
| irq_mask | output | 8 | Interrupt mask |
| stat_isr | output | 1 | Status read selects in-service register |

## Verification
Two events can fall in the same cycle: an opening word can arrive while an earlier sequence is still waiting for its third or fourth word, and it can come right after an operation write has loaded the mask or status select. The bench provokes the first by writing an opening word mid-sequence and by writing two opening words back to back. It provokes the second by following a mask load and a status select directly with a restart. The behavioural model is a queue of expected word kinds. It judges each cycle on whether the restart discards the pending words and overrides the operation state, and on whether `init_clr` marks only the cycle that follows each opening word.

// File: rtl/icw_pkg.sv
package icw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } seq_st_t;

  typedef struct packed {
    logic level;
    logic intv4;
    logic single;
    logic need4;
    logic mode86;
    logic aeoi;
    logic buffered;
  } icw_cfg_t;
endpackage

// File: rtl/icw_rst_sync.sv
module icw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/icw_seq_fsm.sv
module icw_seq_fsm
  import icw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    open_wr,
  input  logic    data_wr,
  input  logic    single,
  input  logic    need4,
  output seq_st_t state
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (open_wr) begin
      st_d = ST_W2;
    end else if (data_wr) begin
      case (st_q)
        ST_W2:   st_d = !single ? ST_W3 : (need4 ? ST_W4 : ST_RUN);
        ST_W3:   st_d = need4 ? ST_W4 : ST_RUN;
        ST_W4:   st_d = ST_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/icw_cfg_regs.sv
module icw_cfg_regs
  import icw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PG_HI = 8,
  parameter int PG_LO = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seq_st_t                state,
  input  logic                   open_wr,
  input  logic                   data_wr,
  input  logic                   cmd_wr,
  input  logic [DW-1:0]          wdata,
  output icw_cfg_t               cfg,
  output logic [PG_HI+PG_LO-1:0] page,
  output logic [DW-1:0]          casc,
  output logic [DW-1:0]          mask,
  output logic                   sel_isr,
  output logic                   clr
);
  icw_cfg_t              cfg_q, cfg_d;
  logic [PG_HI-1:0]      pg_hi_q, pg_hi_d;
  logic [PG_LO-1:0]      pg_lo_q, pg_lo_d;
  logic [DW-1:0]         casc_q, casc_d, mask_q, mask_d;
  logic                  sel_q, sel_d, clr_q;
  logic                  run;

  assign run = (state == ST_RUN);

  always_comb begin
    cfg_d   = cfg_q;
    pg_hi_d = pg_hi_q;
    pg_lo_d = pg_lo_q;
    casc_d  = casc_q;
    mask_d  = mask_q;
    sel_d   = sel_q;
    if (open_wr) begin
      cfg_d.need4    = wdata[0];
      cfg_d.single   = wdata[1];
      cfg_d.intv4    = wdata[2];
      cfg_d.level    = wdata[3];
      cfg_d.mode86   = 1'b0;
      cfg_d.aeoi     = 1'b0;
      cfg_d.buffered = 1'b0;
      pg_lo_d        = wdata[DW-1 -: PG_LO];
      mask_d         = '0;
      sel_d          = 1'b0;
    end else if (data_wr) begin
      case (state)
        ST_W2:  pg_hi_d = wdata[PG_HI-1:0];
        ST_W3:  casc_d  = wdata;
        ST_W4: begin
          cfg_d.mode86   = wdata[0];
          cfg_d.aeoi     = wdata[1];
          cfg_d.buffered = wdata[3];
        end
        ST_RUN: mask_d  = wdata;
        default: ;
      endcase
    end else if (cmd_wr && run && wdata[3] && wdata[1]) begin
      sel_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      pg_hi_q <= '0;
      pg_lo_q <= '0;
      casc_q  <= '0;
      mask_q  <= '0;
      sel_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      pg_hi_q <= pg_hi_d;
      pg_lo_q <= pg_lo_d;
      casc_q  <= casc_d;
      mask_q  <= mask_d;
      sel_q   <= sel_d;
      clr_q   <= open_wr;
    end
  end

  assign cfg     = cfg_q;
  assign page    = {pg_hi_q, pg_lo_q};
  assign casc    = casc_q;
  assign mask    = mask_q;
  assign sel_isr = sel_q;
  assign clr     = clr_q;
endmodule

// File: rtl/icw_sequencer.sv
module icw_sequencer
  import icw_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2,
  localparam int PG_LO    = 3,
  localparam int PG_W     = DW + PG_LO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_a0,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_a0,
  input  logic [DW-1:0]   irr_in,
  input  logic [DW-1:0]   isr_in,
  output logic [DW-1:0]   rd_data,
  output logic            init_clr,
  output logic            init_done,
  output logic            cfg_level,
  output logic            cfg_intv4,
  output logic            cfg_single,
  output logic            cfg_need4,
  output logic            cfg_mode86,
  output logic            cfg_aeoi,
  output logic            cfg_buffered,
  output logic [PG_W-1:0] vec_page,
  output logic [DW-1:0]   casc_cfg,
  output logic [DW-1:0]   irq_mask,
  output logic            stat_isr
);
  logic     rst_n_s;
  logic     open_wr, data_wr, cmd_wr;
  seq_st_t  state;
  icw_cfg_t cfg;

  assign open_wr = wr_en && !wr_a0 && wr_data[4];
  assign data_wr = wr_en && wr_a0;
  assign cmd_wr  = wr_en && !wr_a0 && !wr_data[4];

  icw_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  icw_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .open_wr (open_wr),
    .data_wr (data_wr),
    .single  (cfg.single),
    .need4   (cfg.need4),
    .state   (state)
  );

  icw_cfg_regs #(.DW(DW), .PG_HI(DW), .PG_LO(PG_LO)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .state   (state),
    .open_wr (open_wr),
    .data_wr (data_wr),
    .cmd_wr  (cmd_wr),
    .wdata   (wr_data),
    .cfg     (cfg),
    .page    (vec_page),
    .casc    (casc_cfg),
    .mask    (irq_mask),
    .sel_isr (stat_isr),
    .clr     (init_clr)
  );

  assign init_done    = (state == ST_RUN);
  assign cfg_level    = cfg.level;
  assign cfg_intv4    = cfg.intv4;
  assign cfg_single   = cfg.single;
  assign cfg_need4    = cfg.need4;
  assign cfg_mode86   = cfg.mode86;
  assign cfg_aeoi     = cfg.aeoi;
  assign cfg_buffered = cfg.buffered;

  assign rd_data = rd_a0 ? irq_mask : (stat_isr ? isr_in : irr_in);
endmodule

// File: rtl/icw_sequencer_chk.sv
module icw_sequencer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_a0,
  input logic [DW-1:0] wr_data,
  input logic          init_clr,
  input logic          init_done,
  input logic          cfg_need4,
  input logic          cfg_mode86,
  input logic          cfg_aeoi,
  input logic          cfg_buffered,
  input logic [DW-1:0] irq_mask,
  input logic          stat_isr
);
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_a0 && wr_data[4]) |=> (init_clr && !init_done));

  p_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_a0 && wr_data[4]) |=> (irq_mask == '0 && !stat_isr));

  p_no_fourth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !cfg_need4) |-> (!cfg_mode86 && !cfg_aeoi && !cfg_buffered));

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && wr_en && wr_a0) |=> (irq_mask == $past(wr_data)));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(irq_mask));

  p_clr_only_after_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_a0 && wr_data[4]) |=> !init_clr);
endmodule

bind icw_sequencer icw_sequencer_chk #(.DW(DW)) chk_i (.*);

// File: tb/icw_sequencer_tb_top.sv
module icw_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_a0 = 1'b0, rd_a0 = 1'b0;
  logic [7:0]  wr_data = '0, irr_in = '0, isr_in = '0;
  logic [7:0]  rd_data, casc_cfg, irq_mask;
  logic [10:0] vec_page;
  logic        init_clr, init_done, cfg_level, cfg_intv4, cfg_single, cfg_need4;
  logic        cfg_mode86, cfg_aeoi, cfg_buffered, stat_isr;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  icw_sequencer dut_i (.*);

  // behavioural reference
  int         pend[$];
  bit         started = 0;
  bit [6:0]   m_cfg = '0;  // level,intv4,single,need4,mode86,aeoi,buffered
  bit [10:0]  m_page = '0;
  bit [7:0]   m_casc = '0, m_mask = '0;
  bit         m_stat = 0, m_clr = 0;

  always @(posedge clk) begin
    m_clr = 0;
    if (wr_en && !wr_a0 && wr_data[4]) begin
      m_clr = 1;
      started = 1;
      m_cfg = {wr_data[3], wr_data[2], wr_data[1], wr_data[0], 3'b000};
      m_page[2:0] = wr_data[7:5];
      m_mask = 0;
      m_stat = 0;
      pend.delete();
      pend.push_back(2);
      if (!wr_data[1]) pend.push_back(3);
      if (wr_data[0])  pend.push_back(4);
    end else if (wr_en && wr_a0) begin
      if (pend.size() > 0) begin
        int k;
        k = pend.pop_front();
        if (k == 2) m_page[10:3] = wr_data;
        else if (k == 3) m_casc = wr_data;
        else begin
          m_cfg[2] = wr_data[0];
          m_cfg[1] = wr_data[1];
          m_cfg[0] = wr_data[3];
        end
      end else if (started) m_mask = wr_data;
    end else if (wr_en && !wr_a0 && started && pend.size() == 0
                 && wr_data[3] && wr_data[1]) begin
      m_stat = wr_data[0];
    end
  end

  function automatic bit m_done();
    return started && pend.size() == 0;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R1 init_clr",  16'(init_clr), 16'(m_clr));
    chk("R7 init_done", 16'(init_done), 16'(m_done()));
    chk("R2 cfg",       16'({cfg_level, cfg_intv4, cfg_single, cfg_need4}), 16'(m_cfg[6:3]));
    chk("R6 icw4 cfg",  16'({cfg_mode86, cfg_aeoi, cfg_buffered}), 16'(m_cfg[2:0]));
    chk("R4 vec_page",  16'(vec_page), 16'(m_page));
    chk("R5 casc_cfg",  16'(casc_cfg), 16'(m_casc));
    chk("R8 irq_mask",  16'(irq_mask), 16'(m_mask));
    chk("R9 stat_isr",  16'(stat_isr), 16'(m_stat));
    chk("R10 rd_data",  16'(rd_data),
        16'(rd_a0 ? m_mask : (m_stat ? isr_in : irr_in)));
  end

  task automatic wr(bit a0, logic [7:0] d);
    @(negedge clk);
    #1;
    wr_en = 1; wr_a0 = a0; wr_data = d;
    rd_a0 = $urandom_range(0, 1);
    irr_in = 8'($urandom); isr_in = 8'($urandom);
    @(negedge clk);
    #1;
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
      rd_a0 = $urandom_range(0, 1);
      irr_in = 8'($urandom); isr_in = 8'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    #2;
    // R11: reset state
    chk("R11 reset done", 16'(init_done), 16'd0);
    chk("R11 reset mask", 16'(irq_mask), 16'd0);
    wr(1, 8'hA5); idle(1);           // R11: ignored before opening word
    chk("R11 pre-init write ignored", 16'(irq_mask), 16'd0);
    // single, no fourth word, interval 4
    wr(0, 8'hF6); wr(1, 8'h12); idle(2);
    chk("R7 two-word sequence done", 16'(init_done), 16'd1);
    wr(1, 8'h3C); idle(1);
    chk("R8 mask load", 16'(irq_mask), 16'h3C);
    wr(0, 8'h0B); idle(1);           // select in-service
    chk("R9 select isr", 16'(stat_isr), 16'd1);
    wr(0, 8'h08); idle(1);           // R9: no read bit, no effect
    wr(0, 8'h19); idle(1);           // R1 R3: restart right after ops
    chk("R3 mask cleared", 16'(irq_mask), 16'd0);
    wr(0, 8'h0B);                    // R7: ignored mid-sequence
    wr(1, 8'h80); wr(1, 8'h04); idle(1);
    chk("R5 waits for fourth", 16'(init_done), 16'd0);
    wr(1, 8'h0B); idle(1);
    chk("R6 fourth word", 16'({cfg_mode86, cfg_aeoi, cfg_buffered}), 16'h7);
    // restart mid-sequence and back to back
    wr(0, 8'h11); wr(1, 8'h44); wr(0, 8'h10); wr(0, 8'h12); idle(1);
    chk("R6 cleared without fourth", 16'({cfg_mode86, cfg_aeoi, cfg_buffered}), 16'h0);
    wr(1, 8'h99); idle(1);
    chk("R1 restart completes", 16'(init_done), 16'd1);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) wr(0, 8'($urandom) | 8'h10);
      else if (sel < 4) wr(0, 8'($urandom) & 8'hEF);
      else if (sel < 8) wr(1, 8'($urandom));
      else idle(1);
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule